// File: doc/BRIEF.md
# Per-Channel Gate Request Mixer

This block decides, for each output channel of a multi-channel low-side switch, whether the gate driver should be asked to turn that channel on. Each channel has four configuration bits:

- a control bit that asks for the channel to be on;
- a pin-routing bit that lets one shared external input pin take part;
- a combine-mode bit that joins control bit and pin with OR or with AND;
- a slow-edge bit that is passed straight on to the gate stage.

The shared pin is asynchronous. It goes through a flop-chain synchronizer before use. The synchronizer clears to low, so a floating or unsampled pin never switches a routed channel on.

The configuration bits come from a register file outside this block. The outputs go to the protection stage, one on-request and one slow-edge select per channel. Both outputs are registered. A change on the configuration bits shows at the outputs after one rising edge. A change on the pin shows after three rising edges: two synchronizer stages, then the output register.

Top module: `gate_req_mixer`

## Requirements
- R1: With a channel's pin-routing bit at 0, that channel's on-request after the next rising edge equals its control bit, whatever the pin level and whatever its combine-mode bit.
- R2: With pin-routing 1 and combine-mode 0 (OR), the on-request after the next edge is the control bit OR the synchronized pin. A high pin therefore acts like a control bit of 1.
- R3: With pin-routing 1 and combine-mode 1 (AND), the on-request after the next edge is the control bit AND the synchronized pin.
- R4: Each channel's slow-edge select after the next rising edge equals that channel's slow-edge bit, where 0 means fast and 1 means slow.
- R5: A level change on the raw pin first appears on the on-requests after the third rising edge that samples it, and not after the first or the second.
- R6: While reset is low at a rising edge, all on-requests and slow-edge selects become 0 and the synchronizer clears to low. In the first two edges after release, a routed OR-mode channel with control bit 0 stays off even if the pin is high.
- R7: Bit n of every configuration vector affects only channel n. Bit n of each vector and port belongs to channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | 1 | Shared external input pin, asynchronous |
| ctl_bits | input | N_CH | Per-channel on command |
| map_bits | input | N_CH | Per-channel pin-routing enable |
| op_bits | input | N_CH | Per-channel combine mode, 0 OR, 1 AND |
| slew_bits | input | N_CH | Per-channel slow-edge bit |
| on_req | output | N_CH | Registered per-channel on-request |
| slow_sel | output | N_CH | Registered per-channel slow-edge select |

## Verification
The bench builds the block with eight channels and a two-stage synchronizer. At that size a walking routing bit can visit every channel, and random vectors cover all mixes of routed, unrouted, OR and AND channels in the same cycle. The short synchronizer makes the three-edge pin latency and the two cleared edges after reset easy to check at exact cycles. A behavioural model keeps a queue of past pin samples and compares both output vectors on every clock.

// File: rtl/gate_req_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the per-channel combine function.
// Assumes one bit per channel in every configuration vector.
package gate_req_pkg;

    typedef enum logic {
        CMB_OR  = 1'b0,
        CMB_AND = 1'b1
    } combine_e;

    // Returns the on-request of one channel from its bits and the synced pin.
    function automatic logic gate_on(input logic ctl, input logic routed,
                                     input combine_e mode, input logic pin);
        logic r;
        if (!routed)
            r = ctl;
        else if (mode == CMB_AND)
            r = ctl & pin;
        else
            r = ctl | pin;
        return r;
    endfunction

endpackage

// File: rtl/gate_req_sync.sv
`timescale 1ns/1ps
// Module: flop-chain synchronizer for the shared input pin.
// Assumes STAGES >= 2. The chain clears to low in reset, so an unsampled
// or floating pin reads as low.
module gate_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], pin_async};
    end

    assign pin_sync = chain_q[STAGES-1];

    // R6
    sync_clear_chk: assert property (@(posedge clk) !rst_n |=> !pin_sync)
        else $error("synchronizer not cleared by reset");

endmodule

// File: rtl/gate_req_cell.sv
`timescale 1ns/1ps
// Module: one channel's combine logic with registered outputs.
// Assumes pin_s is already synchronized to clk.
module gate_req_cell
    import gate_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl,
    input  logic routed,
    input  logic mode_and,
    input  logic slew,
    input  logic pin_s,
    output logic on_q,
    output logic slow_q
);

    logic     on_d;
    combine_e mode;

    // Pick the combine mode and form the next on-request.
    always_comb begin
        mode = mode_and ? CMB_AND : CMB_OR;
        on_d = gate_on(ctl, routed, mode, pin_s);
    end

    // Register the on-request and the slow-edge select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            slow_q <= 1'b0;
        end else begin
            on_q   <= on_d;
            slow_q <= slew;
        end
    end

    // R1
    unrouted_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !routed |=> (on_q == $past(ctl)))
        else $error("unrouted channel does not follow its control bit");

    // R2
    or_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (routed && !mode_and && pin_s) |=> on_q)
        else $error("OR channel off with pin high");

    // R3
    and_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (routed && mode_and && !pin_s) |=> !on_q)
        else $error("AND channel on with pin low");

    // R4
    slew_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (slow_q == $past(slew)))
        else $error("slow-edge select not forwarded");

endmodule

// File: rtl/gate_req_mixer.sv
`timescale 1ns/1ps
// Module: top of the per-channel gate request mixer. It synchronizes the
// shared pin and builds one combine cell per channel.
// Assumes the configuration vectors are synchronous to clk.
module gate_req_mixer #(
    parameter int N_CH        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_raw,
    input  logic [N_CH-1:0] ctl_bits,
    input  logic [N_CH-1:0] map_bits,
    input  logic [N_CH-1:0] op_bits,
    input  logic [N_CH-1:0] slew_bits,
    output logic [N_CH-1:0] on_req,
    output logic [N_CH-1:0] slow_sel
);

    localparam int LAST_CH = N_CH - 1;

    logic pin_s;

    gate_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_raw),
        .pin_sync  (pin_s)
    );

    for (genvar ch = 0; ch <= LAST_CH; ch++) begin : g_ch
        gate_req_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl      (ctl_bits[ch]),
            .routed   (map_bits[ch]),
            .mode_and (op_bits[ch]),
            .slew     (slew_bits[ch]),
            .pin_s    (pin_s),
            .on_q     (on_req[ch]),
            .slow_q   (slow_sel[ch])
        );
    end

    // R6
    reset_outputs_chk: assert property (@(posedge clk)
        !rst_n |=> (on_req == '0 && slow_sel == '0))
        else $error("outputs not cleared by reset");

endmodule

// File: tb/gate_req_mixer_tb.sv
`timescale 1ns/1ps
module gate_req_mixer_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin_raw = 1'b0;
    logic [N-1:0] ctl_bits = '0, map_bits = '0, op_bits = '0, slew_bits = '0;
    logic [N-1:0] on_req, slow_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    bit           pin_q[$];
    logic [N-1:0] exp_on = '0, exp_slow = '0;

    always #4 clk = ~clk;

    gate_req_mixer #(.N_CH(N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
        .ctl_bits(ctl_bits), .map_bits(map_bits), .op_bits(op_bits),
        .slew_bits(slew_bits), .on_req(on_req), .slow_sel(slow_sel)
    );

    task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp,
                       input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: the pin sample from two edges back drives this edge.
    initial begin
        pin_q.push_back(1'b0);
        pin_q.push_back(1'b0);
    end
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_on   = '0;
            exp_slow = '0;
            pin_q    = {};
            pin_q.push_back(1'b0);
            pin_q.push_back(1'b0);
        end else begin
            bit old_pin;
            old_pin = pin_q.pop_front();
            for (int i = 0; i < N; i++) begin
                if (!map_bits[i])      exp_on[i] = ctl_bits[i];
                else if (op_bits[i])   exp_on[i] = ctl_bits[i] && old_pin;
                else                   exp_on[i] = ctl_bits[i] || old_pin;
            end
            exp_slow = slew_bits;
            pin_q.push_back(pin_raw);
        end
    end

    // Compare against the model on every clock, just after the edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic [N-1:0] diff;
            string tag;
            diff = on_req ^ exp_on;
            tag = "R2";
            for (int i = N - 1; i >= 0; i--)
                if (diff[i]) tag = !map_bits[i] ? "R1" : (op_bits[i] ? "R3" : "R2");
            if (!rst_n) tag = "R6";
            chk(on_req, exp_on, tag);
            chk(slow_sel, exp_slow, rst_n ? "R4" : "R6");
        end
    end

    task automatic after_edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        // R6: reset with the pin high and every channel routed in OR mode.
        pin_raw = 1'b1; map_bits = '1; op_bits = '0; ctl_bits = '0; slew_bits = '1;
        after_edges(3);
        chk(on_req, '0, "R6");
        chk(slow_sel, '0, "R6");
        @(negedge clk) rst_n = 1'b1;
        after_edges(1);
        chk(on_req, '0, "R6");
        after_edges(1);
        chk(on_req, '0, "R6");
        after_edges(1);
        chk(on_req, '1, "R5");

        // R5: pin falls; visible only at the third edge.
        @(negedge clk) pin_raw = 1'b0;
        after_edges(1); chk(on_req, '1, "R5");
        after_edges(1); chk(on_req, '1, "R5");
        after_edges(1); chk(on_req, '0, "R5");

        // R7: walk the routing bit with the pin held high.
        @(negedge clk) pin_raw = 1'b1;
        after_edges(3);
        for (int i = 0; i < N; i++) begin
            @(negedge clk) map_bits = N'(1) << i;
            after_edges(1);
            chk(on_req, N'(1) << i, "R7");
        end

        // R3: AND mode follows control while the pin is high, then drops.
        @(negedge clk) begin map_bits = '1; op_bits = '1; ctl_bits = 8'hA5; end
        after_edges(1); chk(on_req, 8'hA5, "R3");
        @(negedge clk) pin_raw = 1'b0;
        after_edges(3); chk(on_req, 8'h00, "R3");

        // R1: unrouted channels ignore the pin in either mode.
        @(negedge clk) begin map_bits = '0; op_bits = 8'h0F; ctl_bits = 8'h3C; pin_raw = 1'b1; end
        after_edges(4); chk(on_req, 8'h3C, "R1");

        // R4: slow-edge bits forwarded after one edge.
        @(negedge clk) slew_bits = 8'h96;
        after_edges(1); chk(slow_sel, 8'h96, "R4");

        // Random phase, checked cycle by cycle against the model.
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            ctl_bits  = N'($urandom);
            map_bits  = N'($urandom);
            op_bits   = N'($urandom);
            slew_bits = N'($urandom);
            if ($urandom_range(3) == 0) pin_raw = ~pin_raw;
            if (k == 1500) rst_n = 1'b0;
            if (k == 1503) rst_n = 1'b1;
        end
        after_edges(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule